// File: doc/BRIEF.md
# Byte String Comparator with Condition Flags

This engine compares two byte strings held in memory and stops at the first pair of bytes that differ. A command names each string by a length and a start address, and supplies a fill byte. In the shared-length form, one length covers both strings. In the two-length form, each string has its own length. When one string runs out first, the fill byte is used in place of its missing bytes until the longer string is used up. The engine fetches one byte at a time through a byte-wide memory read port.

When it finishes, the engine presents the remaining length and the current address of each string. For a string that stopped at a difference, the remaining length counts the mismatching byte and the address points at it. It also presents four condition flags taken from the last byte pair it tested.

Commands, memory requests and results each use valid/ready handshakes. A command is taken only while `cmd_ready` is high, and `cmd_ready` is high only while the engine is idle. A memory request keeps its address stable until it is accepted. The response is a one-cycle `mem_rsp_valid` pulse that always comes after the acceptance and cannot be stalled. A result stays on the outputs, unchanged, until `res_ready` takes it.

Top module: `bstr_compare`

## Requirements
- R1: With `cmd_five`=0, `cmd_len_a` is the length of both strings and `cmd_len_b` is ignored. At the result, `res_len_b` equals `res_len_a`.
- R2: With `cmd_five`=1, string A uses `cmd_len_a`/`cmd_addr_a` and string B uses `cmd_len_b`/`cmd_addr_b`, each on its own.
- R3: Bytes are compared in increasing address order, and the engine stops at the first unequal pair. Each string that still has bytes then reports its remaining length, counting the mismatching byte, and the address of that byte.
- R4: A string that runs out is replaced by `cmd_fill` for the rest of the comparison. Its length stays 0, its pointer stays at start address plus length, and no further reads are made for it.
- R5: Flags come from the last pair tested, with A as the first operand. `res_z`=1 when the strings are equal. `res_c`=1 when A's byte is lower, taken as unsigned. `res_n`=1 when A's byte is lower, taken as signed two's complement. `res_v` is always 0. On equal strings, N and C are 0.
- R6: When both lengths are zero, the result is Z=1, N=C=V=0 and both lengths 0, the pointers equal the command addresses, and no memory read is issued.
- R7: When the strings are equal over the longer length, both remaining lengths are 0, each pointer equals its start address plus its length, and Z=1.
- R8: After reset, `cmd_ready`=1, `res_valid`=0 and `mem_req_valid`=0. While `res_valid`=1 and `res_ready`=0, all result outputs hold steady.
- R9: At most one memory read is outstanding at a time. While a request waits for `mem_req_ready`, its address holds steady. Exactly one read is made for each byte that is tested and not past the end of its string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_five | input | 1 | 1 = separate lengths, 0 = shared length |
| cmd_len_a | input | 16 | Length of string A (both strings in shared form) |
| cmd_addr_a | input | 32 | Start address of string A |
| cmd_len_b | input | 16 | Length of string B (two-length form only) |
| cmd_addr_b | input | 32 | Start address of string B |
| cmd_fill | input | 8 | Pad byte for the shorter string |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Read byte |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_len_a | output | 16 | Remaining length of A |
| res_ptr_a | output | 32 | Current address in A |
| res_len_b | output | 16 | Remaining length of B |
| res_ptr_b | output | 32 | Current address in B |
| res_n | output | 1 | A lower, taken as signed |
| res_z | output | 1 | Strings equal |
| res_v | output | 1 | Always 0 |
| res_c | output | 1 | A lower, taken as unsigned |

## Verification
The hardest case to reach is a mismatch found while the shorter string has already run out. There the fill byte, not memory data, is one operand, and the exhausted pointer must sit frozen at its end. The stimulus builds such strings directly in the bench memory. One case has a short string B whose longer partner A differs from the fill byte. Another has an empty A whose partner is made entirely of fill bytes. A third has a tail made of fill bytes that must count as equal. A pseudo-random memory-ready pattern and a result consumer that holds off for two cycles keep both handshakes stalling throughout.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PICK_A, S_WAIT_A, S_PICK_B, S_WAIT_B, S_COMP, S_DONE
  } bsc_state_e;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} bsc_fetch_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } bsc_flags_t;
endpackage

// File: rtl/bsc_cursor.sv
module bsc_cursor #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              step,
  output logic [LEN_W-1:0]  len_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              empty
);
  assign empty = (len_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ptr_q <= '0;
    end else if (load) begin
      len_q <= len_in;
      ptr_q <= addr_in;
    end else if (step && !empty) begin
      len_q <= len_q - LEN_W'(1);
      ptr_q <= ptr_q + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/bsc_fetch.sv
module bsc_fetch
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              got
);
  bsc_fetch_e st;

  assign req_valid = (st == F_REQ);
  assign got       = (st == F_WAIT) && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      req_addr <= '0;
    end else begin
      case (st)
        F_IDLE: if (go) begin
          st       <= F_REQ;
          req_addr <= addr_in;
        end
        F_REQ:  if (req_ready) st <= F_WAIT;
        F_WAIT: if (rsp_valid) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsc_judge.sv
module bsc_judge
  import bsc_pkg::*;
(
  input  logic [7:0]  byte_a,
  input  logic [7:0]  byte_b,
  output bsc_flags_t  flags,
  output logic        differ
);
  always_comb begin
    flags.z = (byte_a == byte_b);
    flags.c = (byte_a < byte_b);
    flags.n = ($signed(byte_a) < $signed(byte_b));
    flags.v = 1'b0;
    differ  = !flags.z;
  end
endmodule

// File: rtl/bstr_compare.sv
module bstr_compare
  import bsc_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_five,
  input  logic [LEN_W-1:0]  cmd_len_a,
  input  logic [ADDR_W-1:0] cmd_addr_a,
  input  logic [LEN_W-1:0]  cmd_len_b,
  input  logic [ADDR_W-1:0] cmd_addr_b,
  input  logic [7:0]        cmd_fill,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [LEN_W-1:0]  res_len_a,
  output logic [ADDR_W-1:0] res_ptr_a,
  output logic [LEN_W-1:0]  res_len_b,
  output logic [ADDR_W-1:0] res_ptr_b,
  output logic              res_n,
  output logic              res_z,
  output logic              res_v,
  output logic              res_c
);
  localparam int NSTR = 2;

  bsc_state_e  state;
  bsc_flags_t  flags_q, judge_flags;
  logic        differ;
  logic [7:0]  byte_a, byte_b, fill_q;
  logic        load, step, fetch_go, got;
  logic [ADDR_W-1:0] fetch_addr;

  logic [LEN_W-1:0]  len_in [NSTR];
  logic [ADDR_W-1:0] adr_in [NSTR];
  logic [LEN_W-1:0]  len_q  [NSTR];
  logic [ADDR_W-1:0] ptr_q  [NSTR];
  logic [NSTR-1:0]   empty;

  assign len_in[0] = cmd_len_a;
  assign adr_in[0] = cmd_addr_a;
  assign len_in[1] = cmd_five ? cmd_len_b : cmd_len_a;
  assign adr_in[1] = cmd_addr_b;

  for (genvar g = 0; g < NSTR; g++) begin : g_cur
    bsc_cursor #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_cur (
      .clk(clk), .rst_n(rst_n), .load(load),
      .len_in(len_in[g]), .addr_in(adr_in[g]), .step(step),
      .len_q(len_q[g]), .ptr_q(ptr_q[g]), .empty(empty[g])
    );
  end

  bsc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .addr_in(fetch_addr),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid), .got(got)
  );

  bsc_judge u_judge (
    .byte_a(byte_a), .byte_b(byte_b), .flags(judge_flags), .differ(differ)
  );

  always_comb begin
    load       = (state == S_IDLE) && cmd_valid;
    step       = (state == S_COMP) && !differ;
    fetch_go   = ((state == S_PICK_A) && !empty[0]) ||
                 ((state == S_PICK_B) && !empty[1]);
    fetch_addr = (state == S_PICK_A) ? ptr_q[0] : ptr_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      flags_q <= '0;
      byte_a  <= '0;
      byte_b  <= '0;
      fill_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          fill_q  <= cmd_fill;
          flags_q <= '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
          state   <= S_PICK_A;
        end
        S_PICK_A: begin
          if (&empty) state <= S_DONE;
          else if (empty[0]) begin
            byte_a <= fill_q;
            state  <= S_PICK_B;
          end else state <= S_WAIT_A;
        end
        S_WAIT_A: if (got) begin
          byte_a <= mem_rsp_data;
          state  <= S_PICK_B;
        end
        S_PICK_B: begin
          if (empty[1]) begin
            byte_b <= fill_q;
            state  <= S_COMP;
          end else state <= S_WAIT_B;
        end
        S_WAIT_B: if (got) begin
          byte_b <= mem_rsp_data;
          state  <= S_COMP;
        end
        S_COMP: begin
          flags_q <= judge_flags;
          state   <= differ ? S_DONE : S_PICK_A;
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign res_valid = (state == S_DONE);
  assign res_len_a = len_q[0];
  assign res_ptr_a = ptr_q[0];
  assign res_len_b = len_q[1];
  assign res_ptr_b = ptr_q[1];
  assign res_n     = flags_q.n;
  assign res_z     = flags_q.z;
  assign res_v     = flags_q.v;
  assign res_c     = flags_q.c;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_five,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              res_valid,
  input logic              res_ready,
  input logic [LEN_W-1:0]  res_len_a,
  input logic [ADDR_W-1:0] res_ptr_a,
  input logic [LEN_W-1:0]  res_len_b,
  input logic [ADDR_W-1:0] res_ptr_b,
  input logic              res_n,
  input logic              res_z,
  input logic              res_v,
  input logic              res_c
);
  logic shared_len, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_len <= 1'b0;
      pending    <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) shared_len <= !cmd_five;
      if (mem_req_valid && mem_req_ready) pending <= 1'b1;
      else if (mem_rsp_valid) pending <= 1'b0;
    end
  end

  AST_LEN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && shared_len |-> res_len_a == res_len_b); // R1
  AST_STOP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_z |-> (res_len_a != '0 || res_len_b != '0)); // R3
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_z && (res_n || res_c)) && !res_v); // R5
  AST_EQ_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_z |-> res_len_a == '0 && res_len_b == '0); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_len_a) &&
    $stable(res_ptr_a) && $stable(res_len_b) && $stable(res_ptr_b) &&
    $stable({res_n, res_z, res_v, res_c})); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !res_valid); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req_valid); // R9
endmodule

bind bstr_compare bsc_checker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_five(cmd_five), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .res_valid(res_valid), .res_ready(res_ready),
  .res_len_a(res_len_a), .res_ptr_a(res_ptr_a), .res_len_b(res_len_b),
  .res_ptr_b(res_ptr_b), .res_n(res_n), .res_z(res_z), .res_v(res_v),
  .res_c(res_c)
);

// File: tb/sim_bstr_compare.sv
`timescale 1ns/1ps
module sim_bstr_compare;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_five = 0;
  logic [15:0] cmd_len_a = 0, cmd_len_b = 0;
  logic [31:0] cmd_addr_a = 0, cmd_addr_b = 0;
  logic [7:0]  cmd_fill = 0;
  logic mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 0;
  logic [7:0] mem_rsp_data = 0;
  logic res_valid, res_ready = 0;
  logic [15:0] res_len_a, res_len_b;
  logic [31:0] res_ptr_a, res_ptr_b;
  logic res_n, res_z, res_v, res_c;

  bstr_compare u0 (.*);

  logic [7:0] mem [0:1023];
  logic [3:0] lfsr = 4'b1001;
  int rd_cnt = 0;
  int checks = 0, fails = 0;
  bit mon_busy = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[9:0]];
    end
    lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    mem_req_ready <= lfsr[0] | lfsr[2];
    if (cmd_valid && cmd_ready) rd_cnt <= 0;
    else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 1;
  end

  typedef struct {
    string tag;
    logic [15:0] la, lb;
    logic [31:0] pa, pb;
    logic [3:0]  fl;
    int          reads;
  } exp_t;
  exp_t sb [$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(string tag, bit five, int la, int aa, int lb, int ab, logic [7:0] fill);
    exp_t e;
    int ra = la, rb = five ? lb : la;
    logic [31:0] pa = aa, pb = ab;
    logic [7:0] ba, bb;
    e.tag = tag; e.reads = 0; e.fl = 4'b0100;
    while (ra != 0 || rb != 0) begin
      if (ra != 0) begin ba = mem[pa[9:0]]; e.reads++; end else ba = fill;
      if (rb != 0) begin bb = mem[pb[9:0]]; e.reads++; end else bb = fill;
      if (ba != bb) begin
        e.fl = {$signed(ba) < $signed(bb), 1'b0, 1'b0, ba < bb};
        break;
      end
      if (ra != 0) begin ra--; pa++; end
      if (rb != 0) begin rb--; pb++; end
    end
    e.la = 16'(ra); e.lb = 16'(rb); e.pa = pa; e.pb = pb;
    sb.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_five = five; cmd_len_a = 16'(la); cmd_addr_a = aa;
    cmd_len_b = 16'(lb); cmd_addr_b = ab; cmd_fill = fill;
    @(negedge clk);
    cmd_valid = 0;
    cmd_len_b = 16'hBEEF;
  endtask

  task automatic copy(int src, int dst, int n);
    for (int i = 0; i < n; i++) mem[dst + i] = mem[src + i];
  endtask

  initial begin : monitor
    exp_t e;
    logic [99:0] snap;
    forever begin
      @(negedge clk);
      if (res_valid) begin
        mon_busy = 1;
        snap = {res_len_a, res_ptr_a, res_len_b, res_ptr_b, res_n, res_z, res_v, res_c};
        @(negedge clk); @(negedge clk);
        chk("R8", "result held under back-pressure",
            {31'd0, res_valid && snap == {res_len_a, res_ptr_a, res_len_b, res_ptr_b,
             res_n, res_z, res_v, res_c}}, 32'd1);
        if (sb.size() == 0) chk("R8", "unexpected result", 32'd1, 32'd0);
        else begin
          e = sb.pop_front();
          chk(e.tag, "len_a", {16'd0, res_len_a}, {16'd0, e.la});
          chk(e.tag, "ptr_a", res_ptr_a, e.pa);
          chk(e.tag, "len_b", {16'd0, res_len_b}, {16'd0, e.lb});
          chk(e.tag, "ptr_b", res_ptr_b, e.pb);
          chk("R5", {e.tag, " flags nzvc"}, {28'd0, res_n, res_z, res_v, res_c}, {28'd0, e.fl});
          chk("R9", {e.tag, " read count"}, rd_cnt, e.reads);
        end
        res_ready = 1;
        @(negedge clk);
        res_ready = 0;
        mon_busy = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8", "reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R8", "reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R8", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

    copy(16'h100, 16'h200, 8);
    run("R1 R7 shared equal", 0, 8, 'h100, 99, 'h200, 8'h00);

    copy(16'h140, 16'h240, 6);
    mem['h143] = 8'h10; mem['h243] = 8'h90;
    run("R1 R3 shared mismatch", 0, 6, 'h140, 0, 'h240, 8'h00);

    copy(16'h180, 16'h280, 5);
    mem['h182] = 8'h90; mem['h282] = 8'h10;
    run("R2 R3 separate mismatch", 1, 5, 'h180, 9, 'h280, 8'h00);

    copy(16'h300, 16'h340, 3);
    for (int i = 3; i < 6; i++) mem['h340 + i] = 8'h20;
    run("R4 R7 fill tail equal", 1, 3, 'h300, 6, 'h340, 8'h20);

    copy(16'h380, 16'h3C0, 2);
    for (int i = 2; i < 7; i++) mem['h380 + i] = 8'h41;
    run("R4 R3 fill mismatch", 1, 7, 'h380, 2, 'h3C0, 8'h20);

    run("R6 both empty", 1, 0, 'h123, 0, 'h321, 8'h55);
    run("R6 shared empty", 0, 0, 'h010, 7, 'h020, 8'h55);

    for (int i = 0; i < 3; i++) mem['h50 + i] = 8'h7F;
    run("R4 R6 empty A vs fill", 1, 0, 'h040, 3, 'h050, 8'h7F);

    mem['h60] = 8'hFF; mem['h70] = 8'h01;
    run("R3 R5 single byte", 0, 1, 'h060, 0, 'h070, 8'h00);

    for (int k = 0; k < 4; k++) begin
      copy(16'h000 + k * 16, 16'h080 + k * 16, k + 2);
      run("R2 R3 pattern", 1, k + 3, k * 16, k + 5, 'h080 + k * 16, 8'(k * 9));
    end

    while (sb.size() != 0 || mon_busy || res_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule